// File: doc/BRIEF.md
# Programmable Memory-Cycle Micro-Sequencer

This block produces the control strobes for an external memory device from a small pattern RAM of 32-bit microwords. It issues one microword per clock. Each word sets the chip-select, write-enable, output-enable and general-purpose output levels for that cycle. A pattern ends after the first word whose end flag is set. Software sets up the block through two registers: a mode register, which holds a two-bit operation code and a RAM pointer, and a 32-bit data register.

A bus access that hits the block's chip-select (`cs_hit`) does one of four things, chosen by the operation code:

- **Normal (00):** runs a fixed read or write pattern.
- **Write (01):** a dummy write access stores the data register into the pattern RAM.
- **Read (10):** a dummy read access copies a RAM word back into the data register.
- **Run (11):** runs a pattern from the pointed-to address.

A `timeout` input ends the current pattern early. It diverts execution to a fixed exception pattern, which takes the strobes down in an orderly way.

Top module: `cyc_microseq`

Microword layout, used throughout:

| Bits | Meaning |
|---|---|
| 31 | end flag |
| 30 | acknowledge |
| 29:28 | address-multiplex code |
| 27 | chip-select level |
| 26 | write-enable level |
| 25 | output-enable level |
| 7:0 | general-purpose outputs |
| 24:8 | unused |

## Requirements
- R1: After reset the block is in the following state: `busy` is 0; the operation code, pointer and data register are 0; all memory strobes, `mem_gpo`, `mem_ale` and `ack` are 0.
- R2: A register write while idle updates one register. With `reg_sel`=0 it loads the operation code from `reg_wdata[9:8]` and the pointer from `reg_wdata[5:0]`. With `reg_sel`=1 it loads the data register from `reg_wdata`. The new values appear on `op_q`, `addr_q` and `mdr_q` on the next cycle.
- R3: In write mode (01), a hit with `hit_wr`=1 does three things: it holds `busy` high for exactly one cycle, stores the data register at the pointed RAM word, and then increments the pointer by one. A hit with `hit_wr`=0 in this mode is ignored.
- R4: In read mode (10), a hit with `hit_wr`=0 does three things: it holds `busy` high for one cycle, copies the pointed RAM word into the data register, and increments the pointer.
- R5: The pointer wraps from 63 to 0.
- R6: In run mode (11), any hit starts execution at the pointer address, from the next cycle. Execution steps through consecutive words, one per cycle, with `busy` high, and returns to idle after the first word that has bit 31 set. While a word is issued, `mem_cs`, `mem_we`, `mem_oe` and `mem_gpo` equal bits 27, 26, 25 and 7:0 of that word.
- R7: During a run-mode pattern, `ack` stays 0 whatever bit 30 of the issued words holds.
- R8: `mem_ale` is high in a cycle only when the issued word's bits 29:28 differ from those of the previously issued word. For the first word of a pattern, the comparison is against 00.
- R9: In normal mode (00), a read hit runs the pattern at address 0 and a write hit runs the pattern at address 8. `ack` is high in each cycle whose issued word has bit 30 set.
- R10: If `timeout` is high while a word is issued, the next issued word is the one at address 60. Execution then continues to that pattern's end word. `ack` stays 0 in the exception pattern, and `timeout` has no effect while the exception pattern runs.
- R11: Register writes while `busy` is high are ignored.
- R12: While idle, every memory output and `ack` is 0. A hit while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| reg_wr | input | 1 | register write strobe |
| reg_sel | input | 1 | 0 = mode register, 1 = data register |
| reg_wdata | input | 32 | register write data |
| cs_hit | input | 1 | one-cycle pulse for a bus access that hits the chip-select |
| hit_wr | input | 1 | direction of that access, 1 = write |
| timeout | input | 1 | bus-monitor timeout |
| busy | output | 1 | dummy transaction or pattern in progress |
| op_q | output | 2 | current operation code |
| addr_q | output | 6 | current RAM pointer |
| mdr_q | output | 32 | data register |
| mem_cs | output | 1 | memory chip-select level |
| mem_we | output | 1 | memory write-enable level |
| mem_oe | output | 1 | memory output-enable level |
| mem_gpo | output | 8 | general-purpose output levels |
| mem_ale | output | 1 | address-latch enable |
| ack | output | 1 | transfer acknowledge |

## Verification
The bench uses the default parameters: a 64-word RAM, an 8-bit general-purpose field, read and write bases at 0 and 8, and the exception base at 60. With a 64-word RAM, a write at pointer 63 reaches the wrap to 0. It also lets a single run hit both the normal read pattern and the exception pattern near the top of the RAM. The small fixed bases keep every pattern a few words long, so each issued word is compared in the cycle it appears. Timeouts held across the jump, and hits or register writes made mid-pattern, are checked against the same per-cycle expected stream.

// File: rtl/cyc_microseq.sv
module cyc_microseq #(
  parameter int DEPTH    = 64,
  parameter int AW       = $clog2(DEPTH),
  parameter int GPW      = 8,
  parameter int RD_BASE  = 0,
  parameter int WR_BASE  = 8,
  parameter int EXC_BASE = 60
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr,
  input  logic           reg_sel,
  input  logic [31:0]    reg_wdata,
  input  logic           cs_hit,
  input  logic           hit_wr,
  input  logic           timeout,
  output logic           busy,
  output logic [1:0]     op_q,
  output logic [AW-1:0]  addr_q,
  output logic [31:0]    mdr_q,
  output logic           mem_cs,
  output logic           mem_we,
  output logic           mem_oe,
  output logic [GPW-1:0] mem_gpo,
  output logic           mem_ale,
  output logic           ack
);
  typedef enum logic [1:0] {S_IDLE = 2'd0, S_DUMMY = 2'd1, S_RUN = 2'd2} st_t;

  st_t st;
  logic [31:0]   ram [DEPTH];
  logic [AW-1:0] pc;
  logic [1:0]    prev_amx;
  logic          sw_run, in_exc, dummy_wr;

  wire [31:0] w       = ram[pc];
  wire [1:0]  amx     = w[29:28];
  wire        running = (st == S_RUN);

  logic unused_bits;
  assign unused_bits = ^w[24:GPW];

  assign busy    = (st != S_IDLE);
  assign mem_cs  = running & w[27];
  assign mem_we  = running & w[26];
  assign mem_oe  = running & w[25];
  assign mem_gpo = running ? w[GPW-1:0] : '0;
  assign mem_ale = running && (amx != prev_amx);
  assign ack     = running && !sw_run && !in_exc && w[30];

  always_ff @(posedge clk)
    if (st == S_DUMMY && dummy_wr) ram[addr_q] <= mdr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      op_q     <= '0;
      addr_q   <= '0;
      mdr_q    <= '0;
      pc       <= '0;
      prev_amx <= '0;
      sw_run   <= 1'b0;
      in_exc   <= 1'b0;
      dummy_wr <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          if (reg_wr) begin
            if (reg_sel) mdr_q <= reg_wdata;
            else begin
              op_q   <= reg_wdata[9:8];
              addr_q <= reg_wdata[AW-1:0];
            end
          end
          if (cs_hit) begin
            case (op_q)
              2'b00: begin
                st       <= S_RUN;
                pc       <= hit_wr ? AW'(WR_BASE) : AW'(RD_BASE);
                sw_run   <= 1'b0;
                in_exc   <= 1'b0;
                prev_amx <= 2'b00;
              end
              2'b01: if (hit_wr) begin
                st       <= S_DUMMY;
                dummy_wr <= 1'b1;
              end
              2'b10: if (!hit_wr) begin
                st       <= S_DUMMY;
                dummy_wr <= 1'b0;
              end
              default: begin
                st       <= S_RUN;
                pc       <= addr_q;
                sw_run   <= 1'b1;
                in_exc   <= 1'b0;
                prev_amx <= 2'b00;
              end
            endcase
          end
        end
        S_DUMMY: begin
          if (!dummy_wr) mdr_q <= ram[addr_q];
          addr_q <= addr_q + 1'b1;
          st     <= S_IDLE;
        end
        S_RUN: begin
          prev_amx <= amx;
          if (timeout && !in_exc) begin
            pc     <= AW'(EXC_BASE);
            in_exc <= 1'b1;
          end else if (w[31]) begin
            st <= S_IDLE;
          end else begin
            pc <= pc + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cyc_microseq_chk.sv
module cyc_microseq_chk #(
  parameter int AW       = 6,
  parameter int GPW      = 8,
  parameter int EXC_BASE = 60
) (
  input logic           clk,
  input logic           rst_n,
  input logic           busy,
  input logic           timeout,
  input logic [1:0]     op_q,
  input logic [AW-1:0]  addr_q,
  input logic           mem_cs,
  input logic           mem_we,
  input logic           mem_oe,
  input logic [GPW-1:0] mem_gpo,
  input logic           mem_ale,
  input logic           ack,
  input logic [1:0]     st_code,
  input logic [AW-1:0]  pc,
  input logic           in_exc,
  input logic           sw_run
);
  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(mem_cs | mem_we | mem_oe | mem_ale | ack) && (mem_gpo == '0));

  p_dummy_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_code == 2'd1) |=> (addr_q == AW'($past(addr_q) + 1'b1)));

  p_op_locked_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(op_q));

  p_sw_no_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_code == 2'd2 && sw_run) |-> !ack);

  p_exc_jump_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_code == 2'd2 && timeout && !in_exc) |=>
      (st_code == 2'd2 && pc == AW'(EXC_BASE) && in_exc));

  p_ale_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ale |-> busy);
endmodule

bind cyc_microseq cyc_microseq_chk #(.AW(AW), .GPW(GPW), .EXC_BASE(EXC_BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .timeout(timeout), .op_q(op_q),
  .addr_q(addr_q), .mem_cs(mem_cs), .mem_we(mem_we), .mem_oe(mem_oe),
  .mem_gpo(mem_gpo), .mem_ale(mem_ale), .ack(ack), .st_code(st),
  .pc(pc), .in_exc(in_exc), .sw_run(sw_run)
);

// File: tb/cyc_microseq_test.sv
`timescale 1ns/1ps
module cyc_microseq_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 0, reg_sel = 0, cs_hit = 0, hit_wr = 0, timeout = 0;
  logic [31:0] reg_wdata = '0;
  logic busy, mem_cs, mem_we, mem_oe, mem_ale, ack;
  logic [1:0] op_q;
  logic [5:0] addr_q;
  logic [31:0] mdr_q;
  logic [7:0] mem_gpo;

  always #5 clk = ~clk;

  cyc_microseq uut (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .cs_hit(cs_hit), .hit_wr(hit_wr), .timeout(timeout),
    .busy(busy), .op_q(op_q), .addr_q(addr_q), .mdr_q(mdr_q), .mem_cs(mem_cs),
    .mem_we(mem_we), .mem_oe(mem_oe), .mem_gpo(mem_gpo), .mem_ale(mem_ale), .ack(ack));

  typedef struct packed {
    logic busy, cs, we, oe;
    logic [7:0] gpo;
    logic ale, ack;
  } obs_t;

  obs_t q[$];
  int   rq[$];
  logic [31:0] model [64];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(bit last, bit ta, logic [1:0] amx,
                                     bit cs, bit we, bit oe, logic [7:0] gpo);
    return {last, ta, amx, cs, we, oe, 17'h0, gpo};
  endfunction

  function automatic logic [31:0] mode(logic [1:0] op, logic [5:0] a);
    return {22'd0, op, 2'b00, a};
  endfunction

  // monitor: pops one expected item per cycle while the scoreboard holds any
  initial forever begin
    @(negedge clk);
    #1;
    if (q.size() > 0) begin
      obs_t e, o;
      int r;
      e = q.pop_front();
      r = rq.pop_front();
      o = '{busy, mem_cs, mem_we, mem_oe, mem_gpo, mem_ale, ack};
      check($sformatf("R%0d cycle outputs", r), 32'(o), 32'(e));
    end
  end

  task automatic regw(bit sel, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic dummy(bit wr, bit exp_busy, logic [5:0] exp_addr, string tag);
    @(negedge clk);
    cs_hit = 1; hit_wr = wr;
    @(negedge clk);
    cs_hit = 0;
    check({tag, " busy during dummy"}, 32'(busy), 32'(exp_busy));
    @(negedge clk);
    check({tag, " busy after"}, 32'(busy), 0);
    check({tag, " pointer after"}, 32'(addr_q), 32'(exp_addr));
  endtask

  task automatic prog(logic [5:0] a, logic [31:0] wd);
    regw(0, mode(2'b01, a));
    regw(1, wd);
    dummy(1, 1, a + 6'd1, "R3");
    model[a] = wd;
  endtask

  // driver: hits, then pushes the expected per-cycle stream and drives timeout/pokes
  task automatic run_pat(int start, bit normal, bit hw, int tmo, bit poke, int req);
    int pc = start, n = 0;
    logic [1:0] prev = 2'b00;
    bit exc = 0;
    @(negedge clk);
    cs_hit = 1; hit_wr = hw;
    @(negedge clk);
    cs_hit = 0;
    for (int i = 0; i < 64; i++) begin
      logic [31:0] wd = model[pc];
      q.push_back('{1'b1, wd[27], wd[26], wd[25], wd[7:0], wd[29:28] != prev,
                    normal && !exc && wd[30]});
      rq.push_back(exc ? 10 : req);
      n++;
      prev = wd[29:28];
      if (tmo >= 0 && i >= tmo && !exc) begin
        pc = 60; exc = 1;
      end else if (wd[31]) break;
      else pc = (pc + 1) % 64;
    end
    q.push_back('0);
    rq.push_back(12);
    n++;
    for (int i = 0; i < n; i++) begin
      timeout = (tmo >= 0 && i >= tmo);
      if (poke && i == 1) begin
        reg_wr = 1; reg_sel = 0; reg_wdata = mode(2'b00, 6'd7);
        cs_hit = 1; hit_wr = 0;
      end else begin
        reg_wr = 0; cs_hit = 0;
      end
      @(negedge clk);
    end
    timeout = 0; reg_wr = 0; cs_hit = 0;
    #2;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 busy", 32'(busy), 0);
    check("R1 op", 32'(op_q), 0);
    check("R1 pointer", 32'(addr_q), 0);
    check("R1 data", mdr_q, 0);
    check("R1 strobes", 32'({mem_cs, mem_we, mem_oe, mem_ale, ack, mem_gpo}), 0);
    rst_n = 1;
    // R2 register writes
    regw(0, mode(2'b10, 6'd5));
    check("R2 op", 32'(op_q), 2);
    check("R2 pointer", 32'(addr_q), 5);
    regw(1, 32'hDEADBEEF);
    check("R2 data", mdr_q, 32'hDEADBEEF);

    // R5 wrap while programming the normal read pattern from 63
    prog(6'd63, 32'h1234_5678);
    check("R5 pointer wrapped", 32'(addr_q), 0);
    prog(6'd0, mk(0, 0, 2'b01, 1, 0, 1, 8'h11));
    prog(6'd1, mk(0, 1, 2'b01, 1, 0, 1, 8'h12));
    prog(6'd2, mk(1, 0, 2'b00, 0, 0, 0, 8'h13));
    prog(6'd8, mk(0, 1, 2'b10, 1, 1, 0, 8'h21));
    prog(6'd9, mk(1, 1, 2'b10, 0, 0, 0, 8'h5A));
    prog(6'd20, mk(0, 1, 2'b00, 1, 0, 0, 8'h31));
    prog(6'd21, mk(0, 1, 2'b00, 1, 1, 0, 8'h32));
    prog(6'd22, mk(0, 1, 2'b11, 1, 1, 1, 8'h33));
    prog(6'd23, mk(1, 1, 2'b11, 0, 0, 0, 8'h34));
    for (int i = 0; i < 6; i++)
      prog(6'(30 + i), mk(i == 5, 1, 2'(i % 3), 1, i[0], ~i[0], 8'(8'h40 + i)));
    prog(6'd60, mk(0, 1, 2'b01, 1, 0, 0, 8'h81));
    prog(6'd61, mk(1, 1, 2'b01, 0, 0, 0, 8'h01));

    // R3: read hit in write mode is ignored
    regw(0, mode(2'b01, 6'd40));
    dummy(0, 0, 6'd40, "R3 ignored read hit");

    // R4 readback
    regw(0, mode(2'b10, 6'd20));
    for (int i = 0; i < 4; i++) begin
      dummy(0, 1, 6'(21 + i), "R4");
      check("R4 data readback", mdr_q, model[20 + i]);
    end
    regw(0, mode(2'b10, 6'd63));
    dummy(0, 1, 6'd0, "R5 read wrap");
    check("R4 data at 63", mdr_q, 32'h1234_5678);

    // R9 normal mode read and write patterns
    regw(0, mode(2'b00, 6'd33));
    run_pat(0, 1, 0, -1, 0, 9);
    run_pat(8, 1, 1, -1, 0, 9);
    // R10 timeout in normal read pattern, held through the exception
    run_pat(0, 1, 0, 1, 0, 9);

    // R6 R7 R8 run mode
    regw(0, mode(2'b11, 6'd20));
    run_pat(20, 0, 0, -1, 0, 6);
    run_pat(20, 0, 1, -1, 0, 7);
    // R10 timeout inside a run pattern
    regw(0, mode(2'b11, 6'd30));
    run_pat(30, 0, 0, 2, 0, 8);
    // R11 R12 register write and hit during a pattern
    run_pat(30, 0, 0, -1, 1, 12);
    check("R11 op kept", 32'(op_q), 3);
    check("R11 pointer kept", 32'(addr_q), 30);

    repeat (2) @(negedge clk);
    check("R12 idle strobes", 32'({mem_cs, mem_we, mem_oe, mem_ale, ack, mem_gpo}), 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule